// File: doc/BRIEF.md
# Message-Signalled Interrupt Collector

This block gathers message-signalled interrupts that arrive as single-byte writes and keeps each one as a pending bit. The pending bits live in one of four status banks. The two lowest bits of the byte pick the bank. A bit-index field that starts at byte bit 2 picks the bit inside that bank. Each bank drives its own level interrupt line, so a system can tie each line to a different processor core. Software then steers a source to a core by choosing the bank bits of the byte it programs into that source.

The width of the bit-index field is set by the parameter `IDX_W`. With 5 bits, each bank holds 32 sources. With 3 bits, each bank holds 8 sources, which is 32 sources in total when all four banks serve one core. Any byte bits above the field, and always bit 7, take no part in the encoding.

Software reads a bank through a small register port. It clears serviced bits by writing ones to that bank.

Top module: `msi_collector`

## Requirements
- R1: When `msg_valid` is high at a rising clock edge, the bit selected by `msg_data[IDX_W+1:2]` becomes set in the bank selected by `msg_data[1:0]`, and the change is visible right after that edge.
- R2: Byte bit 7, and any byte bits above bit `IDX_W+1`, have no effect. For example, with `IDX_W`=5, byte 0x80 sets bit 0 of bank 0.
- R3: A message that targets a bit that is already set leaves every bank unchanged. A single clear write then removes the bit.
- R4: `irq[k]` is high exactly when bank k has at least one bit set.
- R5: A write with `reg_wr_en` high clears the bits of the addressed bank where `reg_wdata` holds a one. Bits where `reg_wdata` holds a zero keep their value.
- R6: If a message and a clear hit the same bit of the same bank in the same cycle, the bit ends up set.
- R7: `reg_rdata` always shows the pending bits of bank `reg_addr[1:0]`, zero-extended to 32 bits. Higher address bits play no part.
- R8: Reset (`rst_n` low) clears all four banks, so all `irq` lines go low.
- R9: A clear write changes only the addressed bank. Pending bits in the other banks are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| msg_valid | input | 1 | Incoming message strobe, one message per cycle |
| msg_data | input | 8 | Message byte: bank in [1:0], bit index from bit 2 |
| reg_wr_en | input | 1 | Write-one-to-clear strobe for the addressed bank |
| reg_addr | input | ADDR_W | Register address; bits [1:0] select the bank |
| reg_wdata | input | 32 | Clear mask; low 2^IDX_W bits are used |
| reg_rdata | output | 32 | Pending bits of the addressed bank, zero-extended |
| irq | output | 4 | Level interrupt per bank |

## Verification
The assertions check on every cycle that:
- a message leaves its target bit set on the next cycle, whatever clear arrives with it;
- a clear write with no message leaves none of the masked bits set;
- the banks hold still when no message and no write arrive;
- each interrupt line agrees with what the read port shows for its bank.

Some behaviour only the bench scenarios can show:
- that the decoded bank and bit are the right ones for a wide range of byte patterns, including bytes with bit 7 set;
- that a partial clear spares the unmasked bits;
- that clearing one bank spares the others;
- that high address bits are ignored;
- that a reset in the middle of a run empties every bank.

// File: rtl/msi_collector_pkg.sv
// Shared constants for the message-signalled interrupt collector.
// Assumes a one-byte message and a fixed set of four banks.
package msi_collector_pkg;
    localparam int NUM_BANKS  = 4;
    localparam int BANK_SEL_W = 2;
    localparam int MSG_W      = 8;
    localparam int RD_W       = 32;
    localparam int FIELD_LSB  = BANK_SEL_W;
endpackage

// File: rtl/msi_decode.sv
// Turns one message byte into a one-hot set mask per bank.
// Assumes IDX_W is in 1..5, so the bit field fits below byte bit 7.
// Byte bits above the field are ignored.
module msi_decode
    import msi_collector_pkg::*;
#(
    parameter int IDX_W = 5,
    localparam int SRC  = 1 << IDX_W
) (
    input  logic                              msg_valid,
    input  logic [MSG_W-1:0]                  msg_data,
    output logic [NUM_BANKS-1:0][SRC-1:0]     set_mask
);
    logic [BANK_SEL_W-1:0] bank_sel;
    logic [IDX_W-1:0]      bit_sel;
    logic                  unused_bits;

    assign bank_sel    = msg_data[BANK_SEL_W-1:0];
    assign bit_sel     = msg_data[FIELD_LSB +: IDX_W];
    assign unused_bits = ^msg_data;

    // Build the one-hot set request for the addressed bank.
    always_comb begin
        set_mask = '0;
        if (msg_valid) begin
            set_mask[bank_sel][bit_sel] = 1'b1;
        end
    end
endmodule

// File: rtl/msi_bank.sv
// One pending-status bank: set by messages, cleared by writing ones.
// A set wins over a clear of the same bit in the same cycle.
// Assumes a synchronous active-low reset.
module msi_bank #(
    parameter int SRC = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [SRC-1:0] set_vec,
    input  logic [SRC-1:0] clr_vec,
    output logic [SRC-1:0] pending,
    output logic           irq
);
    logic [SRC-1:0] pend_q;

    // Apply the clear first, then the set, so that a new message wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_vec) | set_vec;
        end
    end

    assign pending = pend_q;

    // The level interrupt is high while any bit is pending.
    always_comb irq = |pend_q;
endmodule

// File: rtl/msi_readmux.sv
// Selects one bank for the read port and zero-extends it to the bus width.
// Purely combinational.
module msi_readmux
    import msi_collector_pkg::*;
#(
    parameter int SRC = 32
) (
    input  logic [NUM_BANKS-1:0][SRC-1:0] pend_all,
    input  logic [BANK_SEL_W-1:0]         sel,
    output logic [RD_W-1:0]               rdata
);
    // Zero-extend the selected bank to the read-data width.
    always_comb rdata = RD_W'(pend_all[sel]);
endmodule

// File: rtl/msi_collector.sv
// Top of the message-signalled interrupt collector.
// Messages set pending bits through the decoder. Register writes clear bits
// in the bank picked by the low address bits. Each bank drives one interrupt.
// Assumes IDX_W in 1..5 and ADDR_W >= 2.
module msi_collector
    import msi_collector_pkg::*;
#(
    parameter int IDX_W  = 5,
    parameter int ADDR_W = 4,
    localparam int SRC   = 1 << IDX_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 msg_valid,
    input  logic [MSG_W-1:0]     msg_data,
    input  logic                 reg_wr_en,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [RD_W-1:0]      reg_wdata,
    output logic [RD_W-1:0]      reg_rdata,
    output logic [NUM_BANKS-1:0] irq
);
    logic [NUM_BANKS-1:0][SRC-1:0] set_mask;
    logic [NUM_BANKS-1:0][SRC-1:0] clr_mask;
    logic [NUM_BANKS-1:0][SRC-1:0] pend_all;
    logic [BANK_SEL_W-1:0]         bank_addr;
    logic                          unused_in;

    assign bank_addr = reg_addr[BANK_SEL_W-1:0];
    assign unused_in = ^{reg_addr, reg_wdata};

    msi_decode #(.IDX_W(IDX_W)) u_decode (
        .msg_valid (msg_valid),
        .msg_data  (msg_data),
        .set_mask  (set_mask)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        // Route the clear mask only to the addressed bank.
        always_comb begin
            clr_mask[g] = '0;
            if (reg_wr_en && (bank_addr == BANK_SEL_W'(g))) begin
                clr_mask[g] = reg_wdata[SRC-1:0];
            end
        end

        msi_bank #(.SRC(SRC)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_vec (set_mask[g]),
            .clr_vec (clr_mask[g]),
            .pending (pend_all[g]),
            .irq     (irq[g])
        );
    end

    msi_readmux #(.SRC(SRC)) u_readmux (
        .pend_all (pend_all),
        .sel      (bank_addr),
        .rdata    (reg_rdata)
    );
endmodule

// File: rtl/msi_collector_chk.sv
// Property checker for msi_collector, bound to every instance of it.
// Observes the ports and the flattened pending state.
module msi_collector_chk
    import msi_collector_pkg::*;
#(
    parameter int IDX_W  = 5,
    parameter int ADDR_W = 4,
    localparam int SRC   = 1 << IDX_W
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     msg_valid,
    input logic [MSG_W-1:0]         msg_data,
    input logic                     reg_wr_en,
    input logic [ADDR_W-1:0]        reg_addr,
    input logic [RD_W-1:0]          reg_wdata,
    input logic [RD_W-1:0]          reg_rdata,
    input logic [NUM_BANKS-1:0]     irq,
    input logic [NUM_BANKS*SRC-1:0] pend_flat
);
    logic [BANK_SEL_W+IDX_W-1:0] msg_pos;
    logic [BANK_SEL_W-1:0]       sel_q;
    logic [SRC-1:0]              mask_q;
    logic                        clr_chk_q;
    logic [SRC-1:0]              sel_bank_now;
    logic                        unused_chk;

    assign msg_pos      = {msg_data[BANK_SEL_W-1:0], msg_data[FIELD_LSB +: IDX_W]};
    assign sel_bank_now = SRC'(pend_flat >> {sel_q, IDX_W'(0)});
    assign unused_chk   = ^{msg_data, reg_addr, reg_wdata};

    // Remember a pure clear write so that its result can be checked next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_chk_q <= 1'b0;
            sel_q     <= '0;
            mask_q    <= '0;
        end else begin
            clr_chk_q <= reg_wr_en && !msg_valid;
            sel_q     <= reg_addr[BANK_SEL_W-1:0];
            mask_q    <= reg_wdata[SRC-1:0];
        end
    end

    // R1 R6
    msg_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |=> pend_flat[$past(msg_pos)]);

    // R5
    clear_takes_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_chk_q |-> ((sel_bank_now & mask_q) == '0));

    // R3 R9
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!msg_valid && !reg_wr_en) |=> $stable(pend_flat));

    // R4 R7
    irq_matches_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq[reg_addr[BANK_SEL_W-1:0]] == (reg_rdata != '0));
endmodule

bind msi_collector msi_collector_chk #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .msg_valid (msg_valid),
    .msg_data  (msg_data),
    .reg_wr_en (reg_wr_en),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq),
    .pend_flat (pend_all)
);

// File: tb/msi_collector_test.sv
// Self-checking bench for msi_collector at its default parameters (IDX_W=5).
module msi_collector_test;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              msg_valid = 1'b0;
    logic [7:0]        msg_data = '0;
    logic              reg_wr_en = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [3:0]        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msi_collector #(.IDX_W(5), .ADDR_W(ADDR_W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .msg_valid (msg_valid),
        .msg_data  (msg_data),
        .reg_wr_en (reg_wr_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    // Vector layout: {message byte, 1'b0, expected bank[1:0], expected bit[4:0]}.
    localparam logic [15:0] VEC [10] = '{
        {8'h00, 1'b0, 2'd0, 5'd0},
        {8'h01, 1'b0, 2'd1, 5'd0},
        {8'h02, 1'b0, 2'd2, 5'd0},
        {8'h03, 1'b0, 2'd3, 5'd0},
        {8'h7C, 1'b0, 2'd0, 5'd31},
        {8'h7F, 1'b0, 2'd3, 5'd31},
        {8'h80, 1'b0, 2'd0, 5'd0},
        {8'hD5, 1'b0, 2'd1, 5'd21},
        {8'h2A, 1'b0, 2'd2, 5'd10},
        {8'h47, 1'b0, 2'd3, 5'd17}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    task automatic send_msg(input logic [7:0] b);
        @(negedge clk);
        msg_valid = 1'b1;
        msg_data  = b;
        @(negedge clk);
        msg_valid = 1'b0;
    endtask

    task automatic clear_bits(input logic [ADDR_W-1:0] a, input logic [31:0] m);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_addr  = a;
        reg_wdata = m;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic read_bank(input logic [ADDR_W-1:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: every bank is empty after reset.
        for (int k = 0; k < 4; k++) begin
            read_bank(ADDR_W'(k), v);
            check(v == 0, "R8 bank empty", v, 0);
        end
        check(irq == 4'b0, "R8 irq low", 32'(irq), 0);

        // R1 R2 R4 R5: walk the vector table.
        for (int i = 0; i < 10; i++) begin
            logic [7:0]  b;
            logic [1:0]  bk;
            logic [31:0] exp;
            b   = VEC[i][15:8];
            bk  = VEC[i][6:5];
            exp = 32'd1 << VEC[i][4:0];
            send_msg(b);
            read_bank(ADDR_W'(bk), v);
            check(v == exp, "R1 R2 decoded bit", v, exp);
            check(irq == (4'b1 << bk), "R4 irq line", 32'(irq), 32'(4'b1 << bk));
            clear_bits(ADDR_W'(bk), 32'hFFFF_FFFF);
            read_bank(ADDR_W'(bk), v);
            check(v == 0, "R5 cleared", v, 0);
            check(irq == 4'b0, "R4 irq drops", 32'(irq), 0);
        end

        // R3: a repeated message changes nothing; one clear removes the bit.
        send_msg(8'h09);
        send_msg(8'h09);
        read_bank(ADDR_W'(1), v);
        check(v == 32'h4, "R3 double set", v, 32'h4);
        clear_bits(ADDR_W'(1), 32'h4);
        read_bank(ADDR_W'(1), v);
        check(v == 0, "R3 single clear", v, 0);

        // R5: a partial clear spares the bits where the mask is zero.
        send_msg(8'h0A);
        send_msg(8'h12);
        clear_bits(ADDR_W'(2), 32'h4);
        read_bank(ADDR_W'(2), v);
        check(v == 32'h10, "R5 partial clear", v, 32'h10);

        // R6: a set and a clear of the same bit in one cycle leave it set.
        @(negedge clk);
        msg_valid = 1'b1;
        msg_data  = 8'h12;
        reg_wr_en = 1'b1;
        reg_addr  = ADDR_W'(2);
        reg_wdata = 32'h10;
        @(negedge clk);
        msg_valid = 1'b0;
        reg_wr_en = 1'b0;
        read_bank(ADDR_W'(2), v);
        check(v == 32'h10, "R6 set wins", v, 32'h10);

        // R9: clearing bank 0 spares bank 2.
        send_msg(8'h04);
        clear_bits(ADDR_W'(0), 32'hFFFF_FFFF);
        read_bank(ADDR_W'(2), v);
        check(v == 32'h10, "R9 other bank kept", v, 32'h10);
        read_bank(ADDR_W'(0), v);
        check(v == 0, "R9 addressed bank cleared", v, 0);

        // R7: the upper address bits are ignored (0xE selects bank 2).
        read_bank(ADDR_W'(4'hE), v);
        check(v == 32'h10, "R7 high address bits", v, 32'h10);

        // R8: a reset mid-run empties every bank.
        send_msg(8'h7F);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            read_bank(ADDR_W'(k), v);
            check(v == 0, "R8 mid-run reset", v, 0);
        end
        check(irq == 4'b0, "R8 irq after reset", 32'(irq), 0);

        finish_run();
    end
endmodule